// File: doc/BRIEF.md
# Multi-Word Vector Arithmetic Engine

This engine runs one big-integer operation at a time on operands that live in a word-addressed operand RAM of 32-bit words. Each operand is found by an 11-bit word pointer and sized by a 9-bit word count. The operations are add, subtract, left shift, right shift, copy and compare. A single start cycle with a one-hot function word launches a job. The engine then drives a single-port RAM with at most one access per cycle. It reads operand words least significant first, propagates carry, borrow or shifted-out bits between words, and writes each result word from the C pointer upward.

When the job ends, the engine pulses `done` for one cycle. In that same cycle it updates its reporting outputs. Compare updates a three-way flag. Every other operation updates the RAM address of the most significant nonzero result word. On request it also updates the bit index of the leading one inside that word. Outside that cycle the reporting outputs hold their values, so software can read the results of the previous job while the next one runs.

Top module: `vec_arith_engine`

## Requirements
- R1: Add (function bit 4) writes A + B as max(a_len, b_len) + 1 words from c_ptr. A shorter operand reads as zero above its length, and the top word holds the final carry.
- R2: Subtract (function bit 5) writes A − B modulo 2^(32·n) as n = max(a_len, b_len) words, with the borrow carried between words.
- R3: Compare (function bit 10) writes nothing to RAM. It zero-extends the shorter operand and sets cmp_flags to 3'b001 if A == B, 3'b010 if A < B and 3'b100 if A > B.
- R4: Copy (function bit 11) writes the a_len words of A unchanged from c_ptr.
- R5: Left shift (function bit 7) writes A shifted left by shift_amt (0 to 31) bits as a_len + 1 words, with zeros shifted in at the bottom.
- R6: Right shift (function bit 6) writes A shifted right by shift_amt (0 to 31) bits as a_len words, with zeros shifted in at the top.
- R7: After any non-compare operation, msw_addr is the address of the most significant nonzero result word. It is c_ptr if the whole result is zero. msw_addr changes only in the cycle where done is high, and a compare leaves it unchanged.
- R8: When function bit 3 is set with a non-compare operation, lead_idx becomes the index of the highest set bit of that word, or 0 for an all-zero result. Without bit 3, or together with compare, lead_idx becomes 0. It changes only in the done cycle.
- R9: A start whose function word does not have exactly one of bits 4, 5, 6, 7, 10, 11 set is ignored. So is a start that arrives while a job runs. An ignored start gives no done pulse and no RAM write.
- R10: The RAM returns read data one cycle after a read. A job with two operands takes 3 cycles per step and one with a single operand takes 2. Add and both shifts take one step more than their word count n. done is a one-cycle pulse in the cycle after the last step. After reset, done, ram_en and all reporting outputs are 0.
- R11: cmp_flags changes only at the end of a compare, and other operations leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch request, sampled while idle |
| func | input | 12 | One-hot operation select plus leading-one request (bit 3) |
| a_ptr | input | 11 | Word address of operand A |
| b_ptr | input | 11 | Word address of operand B |
| c_ptr | input | 11 | Word address of the result |
| a_len | input | 9 | Operand A length in words |
| b_len | input | 9 | Operand B length in words |
| shift_amt | input | 5 | Bit shift amount for the shift operations |
| done | output | 1 | One-cycle end-of-job pulse |
| cmp_flags | output | 3 | One-hot compare result |
| msw_addr | output | 11 | Address of the most significant nonzero result word |
| lead_idx | output | 5 | Bit index of the leading one in that word |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable (read when low) |
| ram_addr | output | 11 | RAM word address |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read data, valid one cycle after a read |

## Verification
The assertions rely on a RAM that answers a read in exactly the next cycle and on operand lengths of at least one word. They also rely on the result region not overlapping an operand, because a word written early would otherwise be read back as operand data. The bench models the RAM with that one-cycle latency and uses only nonzero lengths. It places every result region apart from the operands it reads, and it watches each write to confirm that the write falls inside the result region expected for the job.

// File: rtl/vae_pkg.sv
package vae_pkg;

    localparam int WORD_W = 32;
    localparam int PTR_W  = 11;
    localparam int LEN_W  = 9;
    localparam int SHF_W  = $clog2(WORD_W);
    localparam int LEAD_W = $clog2(WORD_W);
    localparam int FUNC_W = 12;
    localparam int STEP_W = LEN_W + 1;

    // function word bit positions
    localparam int FB_MSONE = 3;
    localparam int FB_ADD   = 4;
    localparam int FB_SUB   = 5;
    localparam int FB_RSH   = 6;
    localparam int FB_LSH   = 7;
    localparam int FB_CMP   = 10;
    localparam int FB_COPY  = 11;

    localparam logic [FUNC_W-1:0] OP_MASK = FUNC_W'((1 << FB_ADD) | (1 << FB_SUB) |
                                                    (1 << FB_RSH) | (1 << FB_LSH) |
                                                    (1 << FB_CMP) | (1 << FB_COPY));

    localparam logic [2:0] CMP_EQ = 3'b001;
    localparam logic [2:0] CMP_LT = 3'b010;
    localparam logic [2:0] CMP_GT = 3'b100;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        OP_ADD, OP_SUB, OP_RSH, OP_LSH, OP_CMP, OP_COPY
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE, PH_RDA, PH_RDB, PH_WR
    } phase_e;

    typedef struct packed {
        op_e              op;
        logic             msone;
        logic [PTR_W-1:0] aptr;
        logic [PTR_W-1:0] bptr;
        logic [PTR_W-1:0] cptr;
        logic [LEN_W-1:0] alen;
        logic [LEN_W-1:0] blen;
        logic [SHF_W-1:0] shamt;
    } job_t;

    function automatic logic func_ok(input logic [FUNC_W-1:0] f);
        return $countones(f & OP_MASK) == 1;
    endfunction

    function automatic op_e func_op(input logic [FUNC_W-1:0] f);
        if (f[FB_ADD])      return OP_ADD;
        else if (f[FB_SUB]) return OP_SUB;
        else if (f[FB_RSH]) return OP_RSH;
        else if (f[FB_LSH]) return OP_LSH;
        else if (f[FB_CMP]) return OP_CMP;
        else                return OP_COPY;
    endfunction

    function automatic logic dual_op(input op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_CMP);
    endfunction

    function automatic logic [LEAD_W-1:0] lead_one(input word_t w);
        logic [LEAD_W-1:0] r;
        r = '0;
        for (int i = 0; i < WORD_W; i++) begin
            if (w[i]) r = LEAD_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/vae_ctrl.sv
module vae_ctrl
    import vae_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [FUNC_W-1:0] func,
    input  logic [PTR_W-1:0]  a_ptr,
    input  logic [PTR_W-1:0]  b_ptr,
    input  logic [PTR_W-1:0]  c_ptr,
    input  logic [LEN_W-1:0]  a_len,
    input  logic [LEN_W-1:0]  b_len,
    input  logic [SHF_W-1:0]  shift_amt,
    output logic              accept,
    output op_e               op,
    output logic              msone,
    output logic [SHF_W-1:0]  shamt,
    output phase_e            phase,
    output logic              rd_a_vld,
    output logic              rd_b_vld,
    output logic              wr_strobe,
    output logic [PTR_W-1:0]  waddr,
    output logic              finish,
    output logic              ram_en,
    output logic              ram_we,
    output logic [PTR_W-1:0]  ram_addr
);

    job_t              job_q;
    phase_e            phase_q;
    logic [STEP_W-1:0] step_q;
    logic [STEP_W-1:0] n_words;
    logic [STEP_W-1:0] last_step;
    logic              is_rsh;
    logic              extra_step;

    assign accept = (phase_q == PH_IDLE) && start && func_ok(func);
    assign op     = job_q.op;
    assign msone  = job_q.msone;
    assign shamt  = job_q.shamt;
    assign phase  = phase_q;

    always_comb begin
        is_rsh     = (job_q.op == OP_RSH);
        extra_step = (job_q.op == OP_ADD) || (job_q.op == OP_LSH) || is_rsh;
        if (dual_op(job_q.op) && (job_q.blen > job_q.alen))
            n_words = STEP_W'(job_q.blen);
        else
            n_words = STEP_W'(job_q.alen);
        last_step = extra_step ? n_words : n_words - STEP_W'(1);
        rd_a_vld  = step_q < STEP_W'(job_q.alen);
        rd_b_vld  = step_q < STEP_W'(job_q.blen);
        wr_strobe = (phase_q == PH_WR) && (job_q.op != OP_CMP) &&
                    !(is_rsh && (step_q == '0));
        waddr     = job_q.cptr + PTR_W'(step_q) - PTR_W'(is_rsh);
        finish    = (phase_q == PH_WR) && (step_q == last_step);
    end

    always_comb begin
        ram_en   = 1'b0;
        ram_addr = '0;
        unique case (phase_q)
            PH_RDA: begin
                ram_en   = rd_a_vld;
                ram_addr = job_q.aptr + PTR_W'(step_q);
            end
            PH_RDB: begin
                ram_en   = rd_b_vld;
                ram_addr = job_q.bptr + PTR_W'(step_q);
            end
            PH_WR: begin
                ram_en   = wr_strobe;
                ram_addr = waddr;
            end
            default: ;
        endcase
    end
    assign ram_we = wr_strobe;

    always_ff @(posedge clk) begin
        if (rst) begin
            job_q   <= '0;
            phase_q <= PH_IDLE;
            step_q  <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (accept) begin
                        job_q.op    <= func_op(func);
                        job_q.msone <= func[FB_MSONE];
                        job_q.aptr  <= a_ptr;
                        job_q.bptr  <= b_ptr;
                        job_q.cptr  <= c_ptr;
                        job_q.alen  <= a_len;
                        job_q.blen  <= b_len;
                        job_q.shamt <= shift_amt;
                        step_q      <= '0;
                        phase_q     <= PH_RDA;
                    end
                end
                PH_RDA:  phase_q <= dual_op(job_q.op) ? PH_RDB : PH_WR;
                PH_RDB:  phase_q <= PH_WR;
                default: begin
                    if (finish) begin
                        phase_q <= PH_IDLE;
                    end else begin
                        step_q  <= step_q + STEP_W'(1);
                        phase_q <= PH_RDA;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/vae_alu.sv
module vae_alu
    import vae_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  phase_e           phase,
    input  op_e              op,
    input  logic [SHF_W-1:0] shamt,
    input  logic             rd_a_vld,
    input  logic             rd_b_vld,
    input  word_t            ram_rdata,
    output word_t            wdata,
    output logic [2:0]       cmp_next
);

    logic                  a_vld_q;
    logic                  b_vld_q;
    word_t                 a_q;
    word_t                 prev_q;
    logic                  carry_q;
    logic [2:0]            cmp_q;
    word_t                 opa;
    word_t                 opb;
    logic                  carry_n;
    logic [WORD_W:0]       sum;
    logic [WORD_W:0]       dif;
    logic [2*WORD_W-1:0]   pair;
    logic [2*WORD_W-1:0]   shl;
    logic [2*WORD_W-1:0]   shr;

    always_comb begin
        opa  = dual_op(op) ? a_q : (a_vld_q ? ram_rdata : '0);
        opb  = b_vld_q ? ram_rdata : '0;
        sum  = {1'b0, opa} + {1'b0, opb} + {{WORD_W{1'b0}}, carry_q};
        dif  = {1'b0, opa} - {1'b0, opb} - {{WORD_W{1'b0}}, carry_q};
        pair = {opa, prev_q};
        shl  = pair << shamt;
        shr  = pair >> shamt;
        carry_n = 1'b0;
        unique case (op)
            OP_ADD:  begin wdata = sum[WORD_W-1:0]; carry_n = sum[WORD_W]; end
            OP_SUB:  begin wdata = dif[WORD_W-1:0]; carry_n = dif[WORD_W]; end
            OP_LSH:  wdata = shl[2*WORD_W-1:WORD_W];
            OP_RSH:  wdata = shr[WORD_W-1:0];
            OP_COPY: wdata = opa;
            default: wdata = '0;
        endcase
        if (opa > opb)      cmp_next = CMP_GT;
        else if (opa < opb) cmp_next = CMP_LT;
        else                cmp_next = cmp_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_vld_q <= 1'b0;
            b_vld_q <= 1'b0;
            a_q     <= '0;
            prev_q  <= '0;
            carry_q <= 1'b0;
            cmp_q   <= CMP_EQ;
        end else begin
            if (phase == PH_RDA) a_vld_q <= rd_a_vld;
            if (phase == PH_RDB) begin
                a_q     <= a_vld_q ? ram_rdata : '0;
                b_vld_q <= rd_b_vld;
            end
            if (clear) begin
                prev_q  <= '0;
                carry_q <= 1'b0;
                cmp_q   <= CMP_EQ;
            end else if (phase == PH_WR) begin
                prev_q  <= opa;
                carry_q <= carry_n;
                cmp_q   <= cmp_next;
            end
        end
    end

endmodule

// File: rtl/vae_tracker.sv
module vae_tracker
    import vae_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic [PTR_W-1:0]  base,
    input  logic              wr,
    input  logic [PTR_W-1:0]  waddr,
    input  word_t             wdata,
    output logic [PTR_W-1:0]  addr_next,
    output logic [LEAD_W-1:0] bit_next
);

    logic [PTR_W-1:0]  addr_q;
    logic [LEAD_W-1:0] bit_q;
    logic              hit;

    always_comb begin
        hit       = wr && (wdata != '0);
        addr_next = hit ? waddr : addr_q;
        bit_next  = hit ? lead_one(wdata) : bit_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            bit_q  <= '0;
        end else if (clear) begin
            addr_q <= base;
            bit_q  <= '0;
        end else begin
            addr_q <= addr_next;
            bit_q  <= bit_next;
        end
    end

endmodule

// File: rtl/vec_arith_engine.sv
module vec_arith_engine
    import vae_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [FUNC_W-1:0] func,
    input  logic [PTR_W-1:0]  a_ptr,
    input  logic [PTR_W-1:0]  b_ptr,
    input  logic [PTR_W-1:0]  c_ptr,
    input  logic [LEN_W-1:0]  a_len,
    input  logic [LEN_W-1:0]  b_len,
    input  logic [SHF_W-1:0]  shift_amt,
    output logic              done,
    output logic [2:0]        cmp_flags,
    output logic [PTR_W-1:0]  msw_addr,
    output logic [LEAD_W-1:0] lead_idx,
    output logic              ram_en,
    output logic              ram_we,
    output logic [PTR_W-1:0]  ram_addr,
    output logic [WORD_W-1:0] ram_wdata,
    input  logic [WORD_W-1:0] ram_rdata
);

    logic              accept;
    op_e               op;
    logic              msone;
    logic [SHF_W-1:0]  shamt;
    phase_e            phase;
    logic              rd_a_vld;
    logic              rd_b_vld;
    logic              wr_strobe;
    logic [PTR_W-1:0]  waddr;
    logic              finish;
    word_t             wdata;
    logic [2:0]        cmp_next;
    logic [PTR_W-1:0]  trk_addr;
    logic [LEAD_W-1:0] trk_bit;

    vae_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .func      (func),
        .a_ptr     (a_ptr),
        .b_ptr     (b_ptr),
        .c_ptr     (c_ptr),
        .a_len     (a_len),
        .b_len     (b_len),
        .shift_amt (shift_amt),
        .accept    (accept),
        .op        (op),
        .msone     (msone),
        .shamt     (shamt),
        .phase     (phase),
        .rd_a_vld  (rd_a_vld),
        .rd_b_vld  (rd_b_vld),
        .wr_strobe (wr_strobe),
        .waddr     (waddr),
        .finish    (finish),
        .ram_en    (ram_en),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr)
    );

    vae_alu u_alu (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .phase     (phase),
        .op        (op),
        .shamt     (shamt),
        .rd_a_vld  (rd_a_vld),
        .rd_b_vld  (rd_b_vld),
        .ram_rdata (ram_rdata),
        .wdata     (wdata),
        .cmp_next  (cmp_next)
    );

    vae_tracker u_trk (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .base      (c_ptr),
        .wr        (wr_strobe),
        .waddr     (waddr),
        .wdata     (wdata),
        .addr_next (trk_addr),
        .bit_next  (trk_bit)
    );

    assign ram_wdata = wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            done      <= 1'b0;
            cmp_flags <= '0;
            msw_addr  <= '0;
            lead_idx  <= '0;
        end else begin
            done <= finish;
            if (finish) begin
                if (op == OP_CMP) begin
                    cmp_flags <= cmp_next;
                    lead_idx  <= '0;
                end else begin
                    msw_addr  <= trk_addr;
                    lead_idx  <= msone ? trk_bit : '0;
                end
            end
        end
    end

endmodule

// File: rtl/vae_chk.sv
module vae_chk
    import vae_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              done,
    input logic [2:0]        cmp_flags,
    input logic [PTR_W-1:0]  msw_addr,
    input logic [LEAD_W-1:0] lead_idx
);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3
    cmp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmp_flags));

    // R11
    cmp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(cmp_flags));

    // R7
    msw_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(msw_addr));

    // R8
    lead_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(lead_idx));

endmodule

bind vec_arith_engine vae_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .done      (done),
    .cmp_flags (cmp_flags),
    .msw_addr  (msw_addr),
    .lead_idx  (lead_idx)
);

// File: tb/vec_arith_engine_tb.sv
module vec_arith_engine_tb;
    import vae_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 1 << PTR_W;
    localparam int WATCHDOG   = 100000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [FUNC_W-1:0] func = '0;
    logic [PTR_W-1:0]  a_ptr = '0, b_ptr = '0, c_ptr = '0;
    logic [LEN_W-1:0]  a_len = '0, b_len = '0;
    logic [SHF_W-1:0]  shift_amt = '0;
    logic              done;
    logic [2:0]        cmp_flags;
    logic [PTR_W-1:0]  msw_addr;
    logic [LEAD_W-1:0] lead_idx;
    logic              ram_en, ram_we;
    logic [PTR_W-1:0]  ram_addr;
    word_t             ram_wdata;
    word_t             ram_rdata;

    word_t mem [MEM_WORDS];

    int n_checks = 0;
    int n_fail   = 0;
    int wr_cnt   = 0;
    int done_cnt = 0;
    bit bad_wr   = 0;
    logic [PTR_W-1:0]  mon_base = '0;
    int                mon_len  = 0;
    logic [PTR_W-1:0]  exp_msw  = '0;
    logic [LEAD_W-1:0] exp_lead = '0;
    logic [2:0]        exp_cmp  = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_arith_engine u_dut (
        .clk(clk), .rst(rst), .start(start), .func(func),
        .a_ptr(a_ptr), .b_ptr(b_ptr), .c_ptr(c_ptr),
        .a_len(a_len), .b_len(b_len), .shift_amt(shift_amt),
        .done(done), .cmp_flags(cmp_flags), .msw_addr(msw_addr), .lead_idx(lead_idx),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    // RAM model with one-cycle read latency
    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) mem[ram_addr] <= ram_wdata;
            else        ram_rdata <= mem[ram_addr];
        end
    end

    // per-cycle monitor of writes and done pulses
    always @(negedge clk) begin
        if (!rst) begin
            if (done) done_cnt++;
            if (ram_en && ram_we) begin
                logic [PTR_W-1:0] off;
                wr_cnt++;
                off = ram_addr - mon_base;
                if (int'(off) >= mon_len) bad_wr = 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic word_t getw(input int base, input int len, input int i);
        if (i < 0 || i >= len) return '0;
        return mem[(base + i) % MEM_WORDS];
    endfunction

    function automatic bit getbit(input int base, input int len, input int i);
        word_t w;
        if (i < 0 || i >= 32 * len) return 1'b0;
        w = getw(base, len, i / 32);
        return w[i % 32];
    endfunction

    task automatic run_op(input string req, input logic [FUNC_W-1:0] f,
                          input int a, input int b, input int c,
                          input int al, input int bl, input int sh, input int hold);
        bit is_add, is_sub, is_rsh, is_lsh, is_cmp, dual, got, ok;
        int n, steps, per, nwr, cnt;
        longint acc;
        longint cy;
        word_t t, wa, wb, act_w, exp_w;
        logic [2:0] cmpv;
        word_t expv[$];
        is_add = f[FB_ADD]; is_sub = f[FB_SUB]; is_rsh = f[FB_RSH];
        is_lsh = f[FB_LSH]; is_cmp = f[FB_CMP];
        dual  = is_add || is_sub || is_cmp;
        n     = (dual && bl > al) ? bl : al;
        steps = (is_add || is_lsh || is_rsh) ? n + 1 : n;
        per   = dual ? 3 : 2;
        nwr   = is_add ? n + 1 : is_cmp ? 0 : is_lsh ? al + 1 : n;
        cmpv  = CMP_EQ;
        cy    = 0;
        for (int w = 0; w < nwr; w++) begin
            wa = getw(a, al, w);
            wb = getw(b, bl, w);
            if (is_add) begin
                acc = longint'(wa) + longint'(wb) + cy;
                t = word_t'(acc);
                cy = acc >>> 32;
            end else if (is_sub) begin
                acc = longint'(wa) - longint'(wb) - cy;
                t = word_t'(acc);
                cy = (acc < 0) ? 1 : 0;
            end else if (is_lsh || is_rsh) begin
                for (int k = 0; k < 32; k++)
                    t[k] = getbit(a, al, is_lsh ? 32*w + k - sh : 32*w + k + sh);
            end else begin
                t = wa;
            end
            expv.push_back(t);
        end
        if (is_cmp) begin
            for (int i = n - 1; i >= 0; i--) begin
                wa = getw(a, al, i);
                wb = getw(b, bl, i);
                if (cmpv == CMP_EQ) begin
                    if (wa > wb)      cmpv = CMP_GT;
                    else if (wa < wb) cmpv = CMP_LT;
                end
            end
            exp_cmp  = cmpv;
            exp_lead = '0;
        end else begin
            exp_msw  = PTR_W'(c);
            exp_lead = '0;
            for (int i = 0; i < expv.size(); i++) begin
                if (expv[i] != '0) begin
                    exp_msw = PTR_W'(c + i);
                    for (int k = 0; k < 32; k++)
                        if (expv[i][k]) exp_lead = LEAD_W'(k);
                end
            end
            if (!f[FB_MSONE]) exp_lead = '0;
        end

        mon_base = PTR_W'(c); mon_len = nwr;
        wr_cnt = 0; done_cnt = 0; bad_wr = 0;
        @(negedge clk);
        func = f; a_ptr = PTR_W'(a); b_ptr = PTR_W'(b); c_ptr = PTR_W'(c);
        a_len = LEN_W'(al); b_len = LEN_W'(bl); shift_amt = SHF_W'(sh);
        start = 1'b1;
        cnt = 0; got = 0;
        while (!got && cnt < 5000) begin
            @(posedge clk); cnt++;
            @(negedge clk);
            if (cnt >= hold) start = 1'b0;
            if (done) got = 1;
        end
        start = 1'b0;
        repeat (3) @(negedge clk);
        // R10: latency counted from the start edge
        check(cnt == steps * per + 1, "R10", "done latency", 64'(cnt), 64'(steps * per + 1));
        check(done_cnt == 1, hold > 1 ? "R9" : "R10", "done pulse count", 64'(done_cnt), 64'd1);
        check(wr_cnt == nwr && !bad_wr, req, "write count/region", 64'(wr_cnt), 64'(nwr));
        ok = 1; act_w = '0; exp_w = '0;
        for (int i = 0; i < nwr; i++) begin
            if (ok && mem[(c + i) % MEM_WORDS] != expv[i]) begin
                ok = 0; act_w = mem[(c + i) % MEM_WORDS]; exp_w = expv[i];
            end
        end
        check(ok, req, "result words", 64'(act_w), 64'(exp_w));
        check(msw_addr == exp_msw, "R7", "msw_addr", 64'(msw_addr), 64'(exp_msw));
        check(lead_idx == exp_lead, "R8", "lead_idx", 64'(lead_idx), 64'(exp_lead));
        check(cmp_flags == exp_cmp, is_cmp ? "R3" : "R11", "cmp_flags", 64'(cmp_flags), 64'(exp_cmp));
    endtask

    task automatic run_ignored(input logic [FUNC_W-1:0] f);
        wr_cnt = 0; done_cnt = 0;
        @(negedge clk);
        func = f; a_ptr = 11'd100; b_ptr = 11'd200; c_ptr = 11'd900;
        a_len = 9'd2; b_len = 9'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (12) @(negedge clk);
        // R9: a start with a bad function word is ignored
        check(done_cnt == 0, "R9", "done after bad function", 64'(done_cnt), 64'd0);
        check(wr_cnt == 0, "R9", "writes after bad function", 64'(wr_cnt), 64'd0);
        check(msw_addr == exp_msw, "R9", "msw after bad function", 64'(msw_addr), 64'(exp_msw));
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected 0", WATCHDOG);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < MEM_WORDS; i++)
            mem[i] = word_t'(i * 32'h9E3779B1) ^ 32'h5A5A0F0F;
        mem[100] = '1; mem[101] = '1; mem[102] = '1;
        mem[200] = 32'd1; mem[201] = 32'd0;
        mem[500] = 32'd0;
        mem[510] = 32'd1; mem[511] = 32'd0;
        for (int i = 0; i < 3; i++) mem[540 + i] = mem[530 + i];
        mem[560] = 32'd5; mem[561] = 32'd7;
        mem[570] = 32'd5; mem[571] = 32'd7; mem[572] = 32'd1;
        mem[580] = 32'd9;
        mem[641] = 32'h0000_0000;
        mem[780] = 32'h0000_0040; mem[781] = 32'h0;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check(!done && !ram_en && msw_addr == '0 && lead_idx == '0 && cmp_flags == '0,
              "R10", "reset state", {done, ram_en, cmp_flags, msw_addr, lead_idx}, 64'd0);

        run_op("R1", 12'h018, 100, 200, 300, 3, 2, 0, 1);   // carry ripples to a new top word
        run_op("R1", 12'h018, 400, 410, 420, 4, 4, 0, 2);   // start held while busy (R9)
        run_op("R2", 12'h028, 500, 510, 520, 1, 2, 0, 1);   // wrap below zero
        run_op("R2", 12'h028, 530, 540, 550, 3, 3, 0, 1);   // all-zero result (R7, R8)
        run_op("R3", 12'h408, 530, 540, 960, 3, 3, 0, 1);   // equal, with leading-one request (R8)
        run_op("R3", 12'h400, 560, 570, 960, 2, 3, 0, 1);   // A < B, longer B
        run_op("R3", 12'h400, 560, 580, 960, 2, 1, 0, 1);   // A > B, shorter B
        run_op("R4", 12'h800, 600, 0,   620, 5, 0, 0, 1);
        run_op("R4", 12'h808, 640, 0,   630, 3, 0, 0, 1);
        run_op("R5", 12'h088, 640, 0,   660, 3, 0, 13, 1);
        run_op("R5", 12'h080, 640, 0,   680, 3, 0, 0, 1);
        run_op("R5", 12'h088, 700, 0,   720, 2, 0, 31, 1);
        run_op("R6", 12'h048, 640, 0,   740, 3, 0, 7, 1);
        run_op("R6", 12'h048, 640, 0,   760, 1, 0, 0, 1);
        run_op("R6", 12'h048, 780, 0,   790, 2, 0, 7, 1);   // result all zero
        run_op("R1", 12'h010, 560, 580, 800, 2, 1, 0, 1);   // cmp_flags kept (R11)
        run_ignored(12'h030);
        run_ignored(12'h008);
        run_ignored(12'h000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule